// File: doc/BRIEF.md
# Epoch-Tagged Fetch Redirect Controller

This block is the fetch half of a two-stage in-order pipeline that guesses the next instruction address. It holds the program counter and a single epoch bit. It reads instruction memory through a combinational port addressed by the program counter. It pushes a bundle into a small queue toward execute. The bundle holds the instruction, its address, its guessed successor (address plus four) and the epoch value at fetch time.

The execute side consumes the head of the queue through a valid/ready handshake. On the cycle it accepts an instruction, it drives the address that really follows that instruction. The block marks the head as live when its epoch tag equals the current epoch, and as squashed otherwise. A live instruction whose real successor differs from its guess causes a redirect. The program counter is loaded with the real successor and the epoch bit is inverted. Wrong-path entries already in the queue are not flushed. Each one is dropped in turn when it reaches the head and execute accepts it.

Back-pressure: a head entry is offered while `exe_valid_o` is high and leaves the queue only on a cycle where `exe_ready_i` is also high. While `exe_ready_i` is low, the head bundle stays constant. Fetch stalls when the queue is full, and the program counter then holds its value. The block always wants to fetch and needs no ready signal from instruction memory.

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: While reset is asserted and on release, the program counter (`imem_addr_o`) is 0, the epoch is 0 and the queue is empty (`exe_valid_o` low).
- R2: Every queued bundle carries its own address, a guessed successor equal to that address plus 4, the memory word read at that address, and the epoch current when it was fetched.
- R3: Each cycle a bundle is pushed and no redirect occurs, the program counter advances by 4. When the queue is full and no redirect occurs, it holds its value.
- R4: The queue holds two entries and delivers them in fetch order. The head stays stable while `exe_ready_i` is low, and one entry leaves per cycle in which valid and ready are both high.
- R5: `exe_live_o` is high exactly when the head's epoch tag (`exe_epoch_o`) equals the current epoch.
- R6: A squashed head that execute accepts is removed from the queue and never causes a redirect, whatever `exe_next_pc_i` holds.
- R7: When execute accepts a live head and `exe_next_pc_i` differs from that head's guessed successor, `redirect_o` goes high in that same cycle and the epoch is inverted at the next edge.
- R8: On a redirect, the program counter is loaded with `exe_next_pc_i`. This holds even when fetch pushes a bundle in the same cycle.
- R9: The epoch is one bit. A second redirect returns it to 0, so instructions fetched after the second redirect carry tag 0 and are live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr_o | output | 32 | Program counter, the instruction memory read address |
| imem_data_i | input | 32 | Instruction word read combinationally at `imem_addr_o` |
| exe_valid_o | output | 1 | Queue head is present |
| exe_ready_i | input | 1 | Execute accepts the head this cycle |
| exe_pc_o | output | 32 | Address of the head instruction |
| exe_ppc_o | output | 32 | Guessed successor of the head instruction |
| exe_inst_o | output | 32 | Head instruction word |
| exe_epoch_o | output | 1 | Epoch tag of the head instruction |
| exe_live_o | output | 1 | Head tag matches the current epoch |
| exe_next_pc_i | input | 32 | Real successor address of the head, sampled when it is accepted |
| redirect_o | output | 1 | A live head was accepted with a wrong guess this cycle |

## Verification
A redirect and a fetch push can land on the same edge. In steady streaming the queue holds one entry, so every accept coincides with a push. The bench forces a wrong successor on such a cycle and judges the outcome at the next falling edge. The program counter must equal the forced target and not the fetch address plus 4. The head must be the squashed instruction that was pushed alongside the redirect. The bench then accepts that squashed entry with a mismatching successor and expects no redirect. It repeats the sequence to walk the epoch bit around and back to 0.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned INST_W  = 32;
  localparam int unsigned PC_STEP = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] ppc;
    logic [INST_W-1:0] inst;
    logic              epoch;
  } fetch_bundle_t;
endpackage

// File: rtl/frc_pc_gen.sv
module frc_pc_gen
  import frc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              epoch_o
);
  logic [ADDR_W-1:0] pc_q;
  logic              epoch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      epoch_q <= 1'b0;
    end else if (redirect_i) begin
      pc_q    <= target_i;
      epoch_q <= ~epoch_q;
    end else if (adv_i) begin
      pc_q    <= pc_q + ADDR_W'(PC_STEP);
    end
  end

  assign pc_o    = pc_q;
  assign epoch_o = epoch_q;

  // R7: a redirect inverts the epoch
  p_epoch_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> (epoch_o != $past(epoch_o)));
  // R9: the epoch only moves on a redirect
  p_epoch_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_i |=> $stable(epoch_o));
endmodule

// File: rtl/frc_queue.sv
module frc_queue
  import frc_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_i,
  input  fetch_bundle_t enq_data_i,
  output logic          full_o,
  input  logic          deq_i,
  output logic          valid_o,
  output fetch_bundle_t head_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  fetch_bundle_t     slots [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (enq_i && (wr_ptr == PW'(g))) slots[g] <= enq_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (enq_i) wr_ptr <= bump(wr_ptr);
      if (deq_i) rd_ptr <= bump(rd_ptr);
      case ({enq_i, deq_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full_o  = (count == CW'(DEPTH));
  assign valid_o = (count != '0);
  assign head_o  = slots[rd_ptr];

  // R4: never more than DEPTH entries, never removal from empty
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> (count <= CW'(1)));
endmodule

// File: rtl/frc_squash.sv
module frc_squash
  import frc_pkg::*;
(
  input  fetch_bundle_t     head_i,
  input  logic              head_valid_i,
  input  logic              ready_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic              cur_epoch_i,
  output logic              live_o,
  output logic              deq_o,
  output logic              redirect_o
);
  assign live_o     = (head_i.epoch == cur_epoch_i);
  assign deq_o      = head_valid_i && ready_i;
  assign redirect_o = deq_o && live_o && (next_pc_i != head_i.ppc);
endmodule

// File: rtl/fetch_redirect_ctrl.sv
module fetch_redirect_ctrl
  import frc_pkg::*;
#(
  parameter int unsigned QDEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] imem_addr_o,
  input  logic [INST_W-1:0] imem_data_i,
  output logic              exe_valid_o,
  input  logic              exe_ready_i,
  output logic [ADDR_W-1:0] exe_pc_o,
  output logic [ADDR_W-1:0] exe_ppc_o,
  output logic [INST_W-1:0] exe_inst_o,
  output logic              exe_epoch_o,
  output logic              exe_live_o,
  input  logic [ADDR_W-1:0] exe_next_pc_i,
  output logic              redirect_o
);
  logic [ADDR_W-1:0] pc;
  logic              epoch;
  logic              q_full, q_valid, deq, redirect, push;
  fetch_bundle_t     fetched, head;

  assign push = !q_full;

  always_comb begin
    fetched.pc    = pc;
    fetched.ppc   = pc + ADDR_W'(PC_STEP);
    fetched.inst  = imem_data_i;
    fetched.epoch = epoch;
  end

  frc_pc_gen u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (push),
    .redirect_i(redirect),
    .target_i  (exe_next_pc_i),
    .pc_o      (pc),
    .epoch_o   (epoch)
  );

  frc_queue #(.DEPTH(QDEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_i     (push),
    .enq_data_i(fetched),
    .full_o    (q_full),
    .deq_i     (deq),
    .valid_o   (q_valid),
    .head_o    (head)
  );

  frc_squash u_sq (
    .head_i      (head),
    .head_valid_i(q_valid),
    .ready_i     (exe_ready_i),
    .next_pc_i   (exe_next_pc_i),
    .cur_epoch_i (epoch),
    .live_o      (exe_live_o),
    .deq_o       (deq),
    .redirect_o  (redirect)
  );

  assign imem_addr_o = pc;
  assign exe_valid_o = q_valid;
  assign exe_pc_o    = head.pc;
  assign exe_ppc_o   = head.ppc;
  assign exe_inst_o  = head.inst;
  assign exe_epoch_o = head.epoch;
  assign redirect_o  = redirect;

  // R2: head guess is its own address plus the step
  p_ppc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid_o |-> (exe_ppc_o == exe_pc_o + ADDR_W'(PC_STEP)));
  // R3: full queue without redirect freezes the program counter
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !redirect) |=> $stable(imem_addr_o));
  // R6: a squashed head never redirects
  p_squash_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid_o && !exe_live_o) |-> !redirect_o);
  // R8: redirect target wins over the fetch advance
  p_redirect_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> (imem_addr_o == $past(exe_next_pc_i)));
  // R4: held head stays put
  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid_o && !exe_ready_i) |=> (exe_valid_o && $stable(exe_pc_o)));
endmodule

// File: tb/fetch_redirect_ctrl_tb.sv
`timescale 1ns/1ps
module fetch_redirect_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, exe_pc, exe_ppc, exe_inst, next_pc;
  logic        exe_valid, exe_ready, exe_epoch, exe_live, redirect;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction
  assign imem_data = mem_word(imem_addr);

  fetch_redirect_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .exe_valid_o(exe_valid), .exe_ready_i(exe_ready), .exe_pc_o(exe_pc),
    .exe_ppc_o(exe_ppc), .exe_inst_o(exe_inst), .exe_epoch_o(exe_epoch),
    .exe_live_o(exe_live), .exe_next_pc_i(next_pc), .redirect_o(redirect)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      report();
    end
  end

  // advance one edge, land mid-low phase
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #0.5;
  endtask

  initial begin
    logic [31:0] p, t, t2, prev;
    exe_ready = 1'b0;
    next_pc   = '0;
    tick(); tick();
    check("R1 pc", imem_addr, 32'h0);
    check("R1 empty", {31'b0, exe_valid}, 32'h0);
    rst_n = 1'b1;
    tick();
    check("R2 valid", {31'b0, exe_valid}, 32'h1);
    check("R2 pc", exe_pc, 32'h0);
    check("R2 ppc", exe_ppc, 32'h4);
    check("R2 inst", exe_inst, mem_word(32'h0));
    check("R5 live", {31'b0, exe_live}, 32'h1);
    check("R1 epoch", {31'b0, exe_epoch}, 32'h0);
    check("R3 advance", imem_addr, 32'h4);
    tick();
    check("R3 advance", imem_addr, 32'h8);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R3 stall", imem_addr, 32'h8);
      check("R4 head hold", exe_pc, 32'h0);
    end
    // stream with correct guesses
    exe_ready = 1'b1;
    prev = 32'hFFFF_FFFC;
    for (int i = 0; i < 24; i++) begin
      next_pc = exe_ppc;
      #0.5;
      check("R7 no redirect", {31'b0, redirect}, 32'h0);
      check("R4 order", exe_pc, prev + 32'h4);
      check("R2 inst", exe_inst, mem_word(exe_pc));
      prev = exe_pc;
      tick();
    end
    check("R3 steady pc", imem_addr, exe_pc + 32'h4);
    // first mispredict, concurrent with a push
    p = exe_pc; t = 32'h0000_0100;
    next_pc = t; #0.5;
    check("R7 redirect", {31'b0, redirect}, 32'h1);
    tick();
    check("R8 target wins", imem_addr, t);
    check("R6 wrong path head", exe_pc, p + 32'h4);
    check("R5 squashed", {31'b0, exe_live}, 32'h0);
    check("R5 old tag", {31'b0, exe_epoch}, 32'h0);
    next_pc = 32'h0000_0000; #0.5;
    check("R6 no redirect", {31'b0, redirect}, 32'h0);
    tick();
    check("R6 removed", exe_pc, t);
    check("R7 epoch flipped", {31'b0, exe_epoch}, 32'h1);
    check("R5 live", {31'b0, exe_live}, 32'h1);
    check("R3 after redirect", imem_addr, t + 32'h4);
    // second mispredict returns the epoch to zero
    t2 = 32'h0000_0040;
    next_pc = t2; #0.5;
    check("R7 redirect", {31'b0, redirect}, 32'h1);
    tick();
    check("R8 target wins", imem_addr, t2);
    check("R5 squashed", {31'b0, exe_live}, 32'h0);
    next_pc = exe_ppc + 32'h8; #0.5;
    check("R6 no redirect", {31'b0, redirect}, 32'h0);
    tick();
    check("R9 head", exe_pc, t2);
    check("R9 epoch back to 0", {31'b0, exe_epoch}, 32'h0);
    check("R9 live", {31'b0, exe_live}, 32'h1);
    // resume streaming; then back-pressure refills
    for (int i = 0; i < 6; i++) begin
      next_pc = exe_ppc; #0.5;
      check("R4 order", exe_pc, t2 + 32'(4 * i));
      tick();
    end
    exe_ready = 1'b0;
    p = exe_pc;
    tick(); tick();
    check("R3 stall", imem_addr, p + 32'h8);
    check("R4 head hold", exe_pc, p);
    report();
  end
endmodule